// File: doc/BRIEF.md
# Scoreboard Issue and Reservation Control

This block sits between the instruction stack and ten functional units of a central processor. It takes one instruction parcel at a time, in a short 15-bit form or a long 30-bit form. It decodes the function code and register fields to find the unit class and the registers the instruction reads and writes. It then checks the unit table and issues the instruction or stalls it. The units are a branch unit, a boolean unit, a shift unit, a floating add unit, a long integer add unit, two multiply units, a divide unit and two increment units.

Each unit slot records what it holds: a busy flag, up to two destination registers and up to two source registers. An instruction issues only when a unit of its class is free, when none of the registers it reads or writes is a pending destination of a busy unit, and when no busy unit still has to read the register it will write. A blocked instruction waits at the input with the stall output high. It issues in the first cycle in which its resources clear. When a unit reports completion, its slot is freed, and that release counts in the same cycle's issue check.

There are three register files of eight entries each: 60-bit operand registers (X), 18-bit address registers (A) and 18-bit index registers (B). Index register zero always reads as zero, so it is never reserved.

Top module: `scoreboard_issue`

## Requirements
- R1: After reset no unit is busy. With `instr_valid` low, `iss_unit` is zero and `instr_stall` is low. The first valid instruction after reset issues at once.
- R2: The function code is `instr_word[29:24]`. Octal 00-07 goes to the branch unit (`iss_unit` bit 0) and octal 10-17 to boolean (bit 1). Octal 20-27 goes to shift (bit 2) and 30-35 to floating add (bit 3). Octal 36-37 goes to long add (bit 4) and 40-43 to multiply (bits 5, 6). Octal 44-47 goes to divide (bit 7) and 50-77 to increment (bits 8, 9).
- R3: A unit that is busy and not completing this cycle takes no instruction. For multiply and increment, the lowest-numbered free instance is chosen. The instruction stalls only when every instance is taken.
- R4: An instruction stalls while any register it reads is a pending destination of a busy unit (read after write).
- R5: An instruction stalls while any register it writes is a pending destination of a busy unit (write after write).
- R6: An instruction stalls while any register it writes is still a source of a busy unit (write after read).
- R7: A completion (`unit_done[u]`) for a busy unit releases its unit and registers before the same cycle's issue check. Without a new issue to that unit, the unit is free on the next cycle.
- R8: At most one `iss_unit` bit is set per cycle. `instr_stall` equals valid and not issued. A held instruction issues in the first cycle its resources clear.
- R9: Index register B0 is never reserved. Reading it never blocks, and writing it reserves nothing.
- R10: Increment codes octal 50-57 write Ai. They also reserve Xi as a destination for i in 1..5 (a memory load) and read Xi as a source for i in 6..7 (a memory store).
- R11: A completion for an idle unit has no effect on issue or on the unit table.
- R12: The fields i (`[23:21]`), j (`[20:18]`), k (`[17:15]`) and K (`[17:0]`) are presented with the issue. `iss_long` is high for codes octal 01-07 and 50-77.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_valid | input | 1 | Instruction parcel present |
| instr_word | input | 30 | Function code, i, j, and k or K |
| instr_stall | output | 1 | Instruction held this cycle |
| iss_unit | output | 10 | One-hot issue strobe per unit |
| iss_fm | output | 6 | Decoded function code |
| iss_i | output | 3 | Destination field i |
| iss_j | output | 3 | Field j |
| iss_k | output | 3 | Field k |
| iss_K | output | 18 | Long-format constant K |
| iss_long | output | 1 | Instruction is in the 30-bit form |
| unit_done | input | 10 | Per-unit completion |

## Verification
On every cycle, the assertions check these behaviours:
- only one strobe is active;
- no busy unit is given a second instruction;
- an issue marks its unit busy;
- a completion frees its unit;
- a stray completion leaves an idle unit idle;
- B0 never appears among the pending destinations.

Whether the register hazards are judged correctly can only be shown by the bench's scenarios. This covers read-after-write, write-after-write and write-after-read stalls, the implied load and store reservations of the address increments, and the lowest-instance choice. The same holds for a held instruction issuing in exactly the cycle its blocker completes. The bench compares these against a behavioural model on every clock.

// File: rtl/scoreboard_issue.sv
module scoreboard_issue #(
  parameter int KW = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           instr_valid,
  input  logic [KW+11:0] instr_word,
  output logic           instr_stall,
  output logic [9:0]     iss_unit,
  output logic [5:0]     iss_fm,
  output logic [2:0]     iss_i,
  output logic [2:0]     iss_j,
  output logic [2:0]     iss_k,
  output logic [KW-1:0]  iss_K,
  output logic           iss_long,
  input  logic [9:0]     unit_done
);
  localparam int IW = KW + 12;
  localparam int NU = 10;
  localparam logic [1:0] FX = 2'd1, FA = 2'd2, FB = 2'd3;
  localparam logic [4:0] NONE = 5'd0;

  logic [5:0] fm;
  logic [2:0] fi, fj, fk;
  assign fm = instr_word[IW-1 -: 6];
  assign fi = instr_word[IW-7 -: 3];
  assign fj = instr_word[IW-10 -: 3];
  assign fk = instr_word[IW-13 -: 3];

  assign iss_fm   = fm;
  assign iss_i    = fi;
  assign iss_j    = fj;
  assign iss_k    = fk;
  assign iss_K    = instr_word[KW-1:0];
  assign iss_long = (fm[5:3] == 3'o0) ? (fm != 6'o00) : (fm[5:3] >= 3'o5);

  function automatic logic [4:0] bx(input logic [2:0] n);
    return {FX, n};
  endfunction
  function automatic logic [4:0] ba(input logic [2:0] n);
    return {FA, n};
  endfunction
  function automatic logic [4:0] bb(input logic [2:0] n);
    return (n == 3'd0) ? NONE : {FB, n};
  endfunction

  logic [NU-1:0] cand;
  logic [4:0] d1, d2, s1, s2;

  always_comb begin
    cand = '0;
    d1 = NONE; d2 = NONE; s1 = NONE; s2 = NONE;
    case (fm[5:3])
      3'o0: begin
        cand[0] = 1'b1;
        if (fm[2:0] == 3'd2) s1 = bb(fi);
        else if (fm[2:0] == 3'd3) s1 = bx(fj);
        else if (fm[2]) begin s1 = bb(fi); s2 = bb(fj); end
      end
      3'o1: begin
        cand[1] = 1'b1;
        d1 = bx(fi);
        if (fm[2:0] != 3'd4) s1 = bx(fj);
        if (fm[2:0] != 3'd0) s2 = bx(fk);
      end
      3'o2: begin
        cand[2] = 1'b1;
        d1 = bx(fi); s1 = bb(fj); s2 = bx(fk);
      end
      3'o3: begin
        if (fm[2:1] == 2'b11) cand[4] = 1'b1;
        else cand[3] = 1'b1;
        d1 = bx(fi); s1 = bx(fj); s2 = bx(fk);
      end
      3'o4: begin
        if (fm[2]) cand[7] = 1'b1;
        else cand[6:5] = 2'b11;
        d1 = bx(fi); s1 = bx(fj); s2 = bx(fk);
      end
      3'o5: begin
        cand[9:8] = 2'b11;
        d1 = ba(fi); s1 = ba(fj);
        if (fi >= 3'd6) s2 = bx(fi);
        else if (fi != 3'd0) d2 = bx(fi);
      end
      3'o6: begin
        cand[9:8] = 2'b11;
        d1 = bb(fi); s1 = bb(fj);
      end
      default: begin
        cand[9:8] = 2'b11;
        d1 = bx(fi); s1 = bx(fj);
      end
    endcase
  end

  logic [NU-1:0] ubusy, ub_eff, free, pick;
  logic [4:0] ud1 [NU];
  logic [4:0] ud2 [NU];
  logic [4:0] us1 [NU];
  logic [4:0] us2 [NU];
  logic [31:0] pend, rdm;
  logic hazard, ok;

  assign ub_eff = ubusy & ~unit_done;

  always_comb begin
    pend = '0;
    rdm  = '0;
    for (int u = 0; u < NU; u++) begin
      if (ub_eff[u]) begin
        pend[ud1[u]] = 1'b1;
        pend[ud2[u]] = 1'b1;
        rdm[us1[u]]  = 1'b1;
        rdm[us2[u]]  = 1'b1;
      end
    end
    pend[7:0] = '0;
    rdm[7:0]  = '0;
  end

  assign hazard = pend[s1] | pend[s2] | pend[d1] | pend[d2] | rdm[d1] | rdm[d2];
  assign free   = cand & ~ub_eff;
  assign pick   = free & (~free + 10'd1);
  assign ok     = instr_valid & (|free) & ~hazard;
  assign iss_unit    = ok ? pick : '0;
  assign instr_stall = instr_valid & ~ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ubusy <= '0;
      for (int u = 0; u < NU; u++) begin
        ud1[u] <= NONE; ud2[u] <= NONE; us1[u] <= NONE; us2[u] <= NONE;
      end
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (iss_unit[u]) begin
          ubusy[u] <= 1'b1;
          ud1[u] <= d1; ud2[u] <= d2; us1[u] <= s1; us2[u] <= s2;
        end else if (unit_done[u]) begin
          ubusy[u] <= 1'b0;
        end
      end
    end
  end

  assert_single_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(iss_unit));

  assert_b0_never_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[{FB, 3'd0}]);

  for (genvar u = 0; u < NU; u++) begin : g_chk
    assert_take_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      iss_unit[u] |-> (!ubusy[u] || unit_done[u]));
    assert_mark_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      iss_unit[u] |=> ubusy[u]);
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_done[u] && !iss_unit[u]) |=> !ubusy[u]);
    assert_idle_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ubusy[u] && !iss_unit[u]) |=> !ubusy[u]);
  end
endmodule

// File: tb/tb_scoreboard_issue.sv
module tb_scoreboard_issue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [29:0] instr_word = '0;
  logic [9:0] unit_done = '0;
  logic instr_stall, iss_long;
  logic [9:0] iss_unit;
  logic [5:0] iss_fm;
  logic [2:0] iss_i, iss_j, iss_k;
  logic [17:0] iss_K;

  always #5 clk = ~clk;

  scoreboard_issue dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_stall(instr_stall), .iss_unit(iss_unit), .iss_fm(iss_fm), .iss_i(iss_i),
    .iss_j(iss_j), .iss_k(iss_k), .iss_K(iss_K), .iss_long(iss_long),
    .unit_done(unit_done));

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string tag = "R1";
  int mb [10];
  int md1 [10], md2 [10], ms1 [10], ms2 [10];

  function automatic int xr(int n); return 8 + n; endfunction
  function automatic int ar(int n); return 16 + n; endfunction
  function automatic int br(int n); return (n == 0) ? 0 : 24 + n; endfunction

  function automatic logic [29:0] op(int fm, int i, int j, int k);
    return {fm[5:0], i[2:0], j[2:0], k[2:0], 15'd0};
  endfunction
  function automatic logic [29:0] opk(int fm, int i, int j, int kk);
    return {fm[5:0], i[2:0], j[2:0], kk[17:0]};
  endfunction

  task automatic decode(input logic [29:0] w, output int lo, output int hi,
                        output int d1, output int d2, output int s1, output int s2,
                        output bit lng);
    int fm, i, j, k;
    fm = int'(w[29:24]); i = int'(w[23:21]); j = int'(w[20:18]); k = int'(w[17:15]);
    d1 = 0; d2 = 0; s1 = 0; s2 = 0;
    lng = (fm >= 'o50) || (fm >= 1 && fm <= 7);
    if (fm < 'o10) begin
      lo = 0; hi = 0;
      if (fm == 2) s1 = br(i);
      if (fm == 3) s1 = xr(j);
      if (fm >= 4) begin s1 = br(i); s2 = br(j); end
    end else if (fm < 'o20) begin
      lo = 1; hi = 1; d1 = xr(i);
      if (fm != 'o14) s1 = xr(j);
      if (fm != 'o10) s2 = xr(k);
    end else if (fm < 'o30) begin
      lo = 2; hi = 2; d1 = xr(i); s1 = br(j); s2 = xr(k);
    end else if (fm < 'o50) begin
      if (fm < 'o36) begin lo = 3; hi = 3; end
      else if (fm < 'o40) begin lo = 4; hi = 4; end
      else if (fm < 'o44) begin lo = 5; hi = 6; end
      else begin lo = 7; hi = 7; end
      d1 = xr(i); s1 = xr(j); s2 = xr(k);
    end else begin
      lo = 8; hi = 9;
      if (fm < 'o60) begin
        d1 = ar(i); s1 = ar(j);
        if (i >= 6) s2 = xr(i); else if (i >= 1) d2 = xr(i);
      end else if (fm < 'o70) begin d1 = br(i); s1 = br(j); end
      else begin d1 = xr(i); s1 = xr(j); end
    end
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [29:0] w, input logic [9:0] d);
    int lo, hi, d1, d2, s1, s2, sel;
    bit lng, haz;
    logic [9:0] exp_u;
    @(negedge clk);
    instr_valid = v; instr_word = w; unit_done = d;
    #1;
    decode(w, lo, hi, d1, d2, s1, s2, lng);
    haz = 0;
    for (int u = 0; u < 10; u++) begin
      if (mb[u] != 0 && !d[u]) begin
        if (md1[u] != 0 && (md1[u] == s1 || md1[u] == s2 || md1[u] == d1 || md1[u] == d2)) haz = 1;
        if (md2[u] != 0 && (md2[u] == s1 || md2[u] == s2 || md2[u] == d1 || md2[u] == d2)) haz = 1;
        if (ms1[u] != 0 && (ms1[u] == d1 || ms1[u] == d2)) haz = 1;
        if (ms2[u] != 0 && (ms2[u] == d1 || ms2[u] == d2)) haz = 1;
      end
    end
    sel = -1;
    for (int u = hi; u >= lo; u--) if (mb[u] == 0 || d[u]) sel = u;
    exp_u = '0;
    if (v && !haz && sel >= 0) exp_u[sel] = 1'b1;
    check("iss_unit", 32'(iss_unit), 32'(exp_u));
    check("instr_stall", 32'(instr_stall), 32'(v && exp_u == 0));
    if (exp_u != 0) begin
      check("iss_long", 32'(iss_long), 32'(lng));
      check("fields", {2'b0, iss_fm, iss_i, iss_j, iss_k, iss_K[14:0]},
            {2'b0, w});
    end
    for (int u = 0; u < 10; u++) if (d[u]) mb[u] = 0;
    if (exp_u != 0) begin
      mb[sel] = 1; md1[sel] = d1; md2[sel] = d2; ms1[sel] = s1; ms2[sel] = s2;
    end
  endtask

  task automatic clear_all();
    step(0, '0, '1);
  endtask

  initial begin
    #(100_000 * 10);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < 10; u++) begin mb[u] = 0; md1[u] = 0; md2[u] = 0; ms1[u] = 0; ms2[u] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    tag = "R1"; step(0, '0, '0); step(1, op('o11, 1, 2, 3), '0);
    clear_all();

    tag = "R2";
    for (int f = 0; f < 64; f++) step(1, opk(f, f % 8, (f + 3) % 8, f * 1237), '1);
    tag = "R12";
    step(1, opk('o53, 2, 3, 18'h2A5C3), '1);
    step(1, op('o26, 4, 5, 6), '1);
    clear_all();

    tag = "R3";
    step(1, op('o40, 1, 2, 3), '0);
    step(1, op('o41, 4, 5, 6), '0);
    step(1, op('o42, 7, 2, 3), '0);
    step(1, op('o42, 7, 2, 3), '0);
    tag = "R7"; step(1, op('o42, 7, 2, 3), 10'b0000100000);
    tag = "R3"; step(1, opk('o61, 1, 2, 5), '0); step(1, opk('o62, 2, 3, 5), '0);
    step(1, opk('o63, 3, 4, 5), '0);
    clear_all();

    tag = "R4";
    step(1, op('o30, 1, 2, 3), '0);
    step(1, op('o11, 4, 1, 5), '0);
    tag = "R8"; step(1, op('o11, 4, 1, 5), '0); step(1, op('o11, 4, 1, 5), 10'b0000001000);
    clear_all();

    tag = "R5";
    step(1, op('o36, 6, 2, 3), '0);
    step(1, op('o20, 6, 1, 4), '0);
    step(1, op('o20, 6, 1, 4), 10'b0000010000);
    clear_all();

    tag = "R6";
    step(1, op('o40, 7, 1, 2), '0);
    step(1, opk('o70, 1, 3, 9), '0);
    step(1, opk('o70, 1, 3, 9), 10'b0000100000);
    clear_all();

    tag = "R9";
    step(1, opk('o60, 0, 1, 4), '0);
    step(1, op('o20, 2, 0, 3), '0);
    step(1, opk('o04, 0, 0, 7), '0);
    clear_all();
    step(1, opk('o61, 3, 1, 4), '0);
    step(1, opk('o05, 3, 0, 7), '0);
    clear_all();

    tag = "R10";
    step(1, opk('o52, 2, 1, 6), '0);
    step(1, op('o10, 3, 2, 0), '0);
    step(1, op('o10, 3, 2, 0), 10'b0100000000);
    clear_all();
    step(1, op('o40, 6, 1, 2), '0);
    step(1, opk('o56, 6, 1, 3), '0);
    step(1, opk('o56, 6, 1, 3), 10'b0000100000);
    clear_all();

    tag = "R11";
    step(1, op('o40, 1, 2, 3), '0);
    step(1, op('o41, 4, 5, 6), '0);
    step(1, op('o43, 5, 6, 7), 10'b0010000100);
    step(1, op('o43, 5, 6, 7), 10'b1000011011);
    clear_all();

    tag = "R8";
    for (int n = 0; n < 3000; n++) begin
      logic [9:0] dd;
      dd = 10'($urandom) & 10'($urandom);
      step(($urandom % 4) != 0, 30'($urandom), dd);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule